// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental rotary or linear encoder into a position count. Each raw line is first synchronised to the kernel clock and then passes through a glitch filter that only accepts a new level once it has held steady for a selectable number of clocks. The filtered pair is decoded with four counts per encoder cycle: each single edge on either phase moves the count by one, upward or downward depending on which phase leads.

The count runs within a range set by an auto-reload value: it wraps to zero above that value and back to that value below zero. A direction output tracks the sense of the most recent step. Two separate single-cycle event pulses mark a reversal, one for up-to-down and one for down-to-up, so a controller can react to a change in rotation without polling. Counting is allowed only while the block is enabled and the timer is set to continuous mode. Outside that state the filters keep tracking the lines, so motion that happens in the meantime is not counted later.

Top module: `quad_enc_counter`

## Requirements
- R1: After reset, count is 0, dir_dn is 0 (up) and both event outputs are 0.
- R2: A filtered phase takes a new raw level only after that level has been seen for N = 2^flt_sel consecutive clocks (flt_sel 0..3 gives N of 1, 2, 4 or 8). A pulse shorter than N clocks has no effect on count.
- R3: The count changes only while en and cont_mode are both 1. Otherwise edges on the phases leave count unchanged.
- R4: Every edge on exactly one filtered phase moves count by one. With phase pair written {A,B}, the order 00,10,11,01,00 counts up and the reverse order counts down.
- R5: A transition in which both filtered phases change in the same clock leaves count and dir_dn unchanged.
- R6: An up step from count equal to reload gives 0.
- R7: A down step from count 0 gives reload.
- R8: dir_dn is 1 after a down step and 0 after an up step, and holds between steps.
- R9: ev_up2dn pulses high for exactly one clock when a down step follows an up step.
- R10: ev_dn2up pulses high for exactly one clock when an up step follows a down step.
- R11: The first step after reset raises no event, whatever its direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Counter enable |
| cont_mode | input | 1 | High when the timer runs in continuous mode |
| flt_sel | input | 2 | Filter length select, N = 2^flt_sel clocks |
| enc_a | input | 1 | Raw encoder phase A |
| enc_b | input | 1 | Raw encoder phase B |
| reload | input | CW | Auto-reload value, top of the count range |
| count | output | CW | Position count |
| dir_dn | output | 1 | Direction of the last step, 1 = down |
| ev_up2dn | output | 1 | One-clock pulse on reversal from up to down |
| ev_dn2up | output | 1 | One-clock pulse on reversal from down to up |

## Verification
The wrap assertions assume that reload stays constant while counting and that count starts within 0..reload. The bench sets reload once, right after reset, and never changes it. The event and direction properties assume the phases are sampled cleanly, and the bench drives them on the falling clock edge only. The bench holds every phase level for longer than the filter latency, except where a glitch is the point of the check, so that each applied edge lands as exactly one filtered edge.

// File: rtl/quad_enc_counter.sv
module quad_enc_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cont_mode,
  input  logic [1:0]    flt_sel,
  input  logic          enc_a,
  input  logic          enc_b,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] count,
  output logic          dir_dn,
  output logic          ev_up2dn,
  output logic          ev_dn2up
);

  logic       raw  [2];
  logic       syn  [2];
  logic       flt  [2];
  logic       fltq [2];
  logic [2:0] stab [2];
  logic [2:0] lim;
  logic       moved;

  assign raw[0] = enc_a;
  assign raw[1] = enc_b;
  assign lim    = 3'((4'd1 << flt_sel) - 4'd1);

  for (genvar i = 0; i < 2; i++) begin : g_flt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        syn[i]  <= 1'b0;
        flt[i]  <= 1'b0;
        fltq[i] <= 1'b0;
        stab[i] <= '0;
      end else begin
        syn[i]  <= raw[i];
        fltq[i] <= flt[i];
        if (syn[i] == flt[i]) stab[i] <= '0;
        else if (stab[i] == lim) begin
          flt[i]  <= syn[i];
          stab[i] <= '0;
        end else stab[i] <= stab[i] + 3'd1;
      end
    end
  end

  logic a_chg, b_chg, step, up, go;
  assign a_chg = flt[0] ^ fltq[0];
  assign b_chg = flt[1] ^ fltq[1];
  assign step  = a_chg ^ b_chg;
  assign up    = a_chg ? (flt[0] != flt[1]) : (flt[0] == flt[1]);
  assign go    = step && en && cont_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      dir_dn   <= 1'b0;
      moved    <= 1'b0;
      ev_up2dn <= 1'b0;
      ev_dn2up <= 1'b0;
    end else begin
      ev_up2dn <= go && moved && !dir_dn && !up;
      ev_dn2up <= go && moved && dir_dn && up;
      if (go) begin
        moved  <= 1'b1;
        dir_dn <= !up;
        if (up) count <= (count >= reload) ? '0 : count + 1'b1;
        else    count <= (count == '0) ? reload : count - 1'b1;
      end
    end
  end

  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_up2dn && ev_dn2up)); // R9
  AST_UP2DN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_up2dn |=> !ev_up2dn); // R9
  AST_DN2UP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dn2up |=> !ev_dn2up); // R10
  AST_UP2DN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_up2dn |-> (dir_dn && !$past(dir_dn))); // R9
  AST_DN2UP_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dn2up |-> (!dir_dn && $past(dir_dn))); // R10
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && cont_mode) |=> $stable(count)); // R3
  AST_BOTH_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (a_chg && b_chg) |=> ($stable(count) && $stable(dir_dn))); // R5
  AST_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (go && up && count == reload) |=> count == '0); // R6
  AST_WRAP_DN: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !up && count == '0 && $stable(reload)) |=> count == $past(reload)); // R7
  AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(moved) |-> !(ev_up2dn || ev_dn2up)); // R11

endmodule

// File: tb/tb_quad_enc_counter.sv
module tb_quad_enc_counter;
  localparam int CW = 16;
  localparam int TCLK = 10;
  localparam logic [CW-1:0] RLD = 16'd5;
  localparam int NV = 12;
  // {A, B, expected count, expected dir_dn}
  localparam logic [CW+2:0] VEC [NV] = '{
    {1'b1,1'b0,16'd1,1'b0}, {1'b1,1'b1,16'd2,1'b0}, {1'b0,1'b1,16'd3,1'b0},
    {1'b0,1'b0,16'd4,1'b0}, {1'b1,1'b0,16'd5,1'b0}, {1'b1,1'b1,16'd0,1'b0},
    {1'b0,1'b1,16'd1,1'b0}, {1'b1,1'b1,16'd0,1'b1}, {1'b1,1'b0,16'd5,1'b1},
    {1'b0,1'b0,16'd4,1'b1}, {1'b0,1'b1,16'd3,1'b1}, {1'b0,1'b0,16'd4,1'b0}};

  logic clk = 0, rst_n = 0, en = 1, cont_mode = 1, enc_a = 0, enc_b = 0;
  logic [1:0] flt_sel = 2'd1;
  logic [CW-1:0] reload = RLD;
  logic [CW-1:0] count;
  logic dir_dn, ev_up2dn, ev_dn2up;
  int nchk = 0, nbad = 0, n_u2d = 0, n_d2u = 0, run_u2d = 0, run_d2u = 0, max_run = 0;

  always #(TCLK/2) clk = ~clk;

  quad_enc_counter #(.CW(CW)) dut (.clk(clk), .rst_n(rst_n), .en(en), .cont_mode(cont_mode),
    .flt_sel(flt_sel), .enc_a(enc_a), .enc_b(enc_b), .reload(reload), .count(count),
    .dir_dn(dir_dn), .ev_up2dn(ev_up2dn), .ev_dn2up(ev_dn2up));

  always @(negedge clk) begin
    if (ev_up2dn) begin run_u2d++; if (run_u2d == 1) n_u2d++; end else run_u2d = 0;
    if (ev_dn2up) begin run_d2u++; if (run_d2u == 1) n_d2u++; end else run_d2u = 0;
    if (run_u2d > max_run) max_run = run_u2d;
    if (run_d2u > max_run) max_run = run_d2u;
  end

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(logic a, logic b, int cyc);
    @(negedge clk); enc_a = a; enc_b = b;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; enc_a = 0; enc_b = 0;
    repeat (3) @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(TCLK * 200000);
    nbad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    int u0, d0;
    repeat (3) @(negedge clk);
    chk("R1 count", int'(count), 0);
    chk("R1 dir", int'(dir_dn), 0);
    chk("R1 events", int'(ev_up2dn) + int'(ev_dn2up), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R4 R6 R7 R8 walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][CW+2], VEC[i][CW+1], 12);
      chk("R4/R6/R7 count", int'(count), int'(VEC[i][CW:1]));
      chk("R8 dir", int'(dir_dn), int'(VEC[i][0]));
    end
    chk("R9 up2dn count", n_u2d, 1);
    chk("R10 dn2up count", n_d2u, 1);
    chk("R9 R10 pulse width", max_run, 1);

    // R11: first step after reset is down, no event
    do_reset();
    u0 = n_u2d; d0 = n_d2u;
    drive(1'b0, 1'b1, 12);
    chk("R7 first down wrap", int'(count), int'(RLD));
    chk("R11 no event", (n_u2d - u0) + (n_d2u - d0), 0);

    // R5: both phases change together
    drive(1'b1, 1'b0, 12);
    chk("R5 count", int'(count), int'(RLD));
    chk("R5 dir", int'(dir_dn), 1);

    // R3: disabled or not continuous
    en = 0;
    drive(1'b1, 1'b1, 12);
    chk("R3 en low", int'(count), int'(RLD));
    en = 1; cont_mode = 0;
    drive(1'b0, 1'b1, 12);
    chk("R3 one-shot", int'(count), int'(RLD));
    cont_mode = 1;
    drive(1'b0, 1'b0, 12);
    chk("R3 resumed", int'(count), 0);

    // R2: filter length 8
    flt_sel = 2'd3;
    drive(1'b1, 1'b0, 6);
    drive(1'b0, 1'b0, 15);
    chk("R2 short glitch", int'(count), 0);
    drive(1'b1, 1'b0, 6);
    chk("R2 before N", int'(count), 0);
    repeat (10) @(negedge clk);
    chk("R2 accepted", int'(count), 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule